// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block sets the timing of conversions for a successive-approximation converter whose analog core sits outside it. It takes a configuration that arrives as plain register fields: the source clock, a divide ratio, sample-length options, a high-speed option, the trigger source, continuous mode and a channel code. It runs a conversion-clock tick from the chosen source. It counts a sample phase and then a conversion phase. When both are done it emits a one-cycle result strobe.

A conversion starts on a control write (software trigger) or on a trigger pulse (hardware trigger). While it runs, an activity flag is high. The averaging and compare stages live downstream. They see the result strobe, and they answer on the accept input in the same cycle to say whether this result completes the operation. An accepted result sets a complete flag. That flag drives the interrupt and the DMA request through their enables.

All clock sources are handled as tick enables in the bus-clock domain. The alternate and asynchronous sources therefore arrive already synchronised as one-cycle tick inputs.

Top module: `adc_conv_timer`

## Requirements
- R1: The source select picks the tick source. 00 ticks every bus cycle, 01 ticks every second bus cycle, 10 follows `alt_tick`, and 11 follows `async_tick`. While the selected tick input is held low, a running conversion makes no progress.
- R2: The divide select passes one source tick in 1, 2, 4 or 8 to the conversion clock, for codes 00, 01, 10 and 11.
- R3: With `long_smp_en` at 0 the sample phase lasts 4 conversion-clock cycles. With it at 1, `long_smp_sel` codes 00, 01, 10 and 11 give 24, 16, 10 and 6 cycles.
- R4: The conversion phase lasts (result bits + 4) conversion-clock cycles, plus 2 more when `hs_en` is 1. `res_mode` 00, 01, 10 and 11 give 8, 12, 10 and 16 bits. The complete flag rises exactly (sample + conversion) × (source divide) × (divide ratio) bus cycles after the clock edge that takes the start.
- R5: With `hw_trig_sel` at 0, a `ctl_wr` pulse starts a conversion and `hw_trig` has no effect.
- R6: With `hw_trig_sel` at 1, `ctl_wr` starts nothing. An `hw_trig` pulse while idle starts a conversion.
- R7: `active` is 1 from the cycle after a start until the edge at which the conversion completes. It is 0 after reset.
- R8: With `cont_en` at 1, a new conversion begins at once after each completion. Result strobes are then spaced by exactly one conversion duration until a control write stops it.
- R9: A channel code of all ones (11111) starts no conversion from either trigger. A control write carrying it stops a running conversion.
- R10: The complete flag sets only on a result strobe with `accept` at 1. A strobe with `accept` at 0 ends the conversion and leaves the flag at 0.
- R11: The complete flag clears on `result_rd` or on `ctl_wr`. A control write during a conversion aborts it and restarts the full duration from that write.
- R12: `irq` follows the complete flag when `irq_en` is 1, and `dma_req` follows it when `dma_en` is 1. Each is 0 when its own enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_sel | input | 2 | Tick source select |
| div_sel | input | 2 | Conversion-clock divide select |
| long_smp_en | input | 1 | Long sample phase enable |
| long_smp_sel | input | 2 | Long sample length code |
| hs_en | input | 1 | High-speed option, adds 2 cycles |
| hw_trig_sel | input | 1 | 0 software trigger, 1 hardware trigger |
| cont_en | input | 1 | Continuous conversion enable |
| res_mode | input | 2 | Result width code |
| chan_sel | input | CHAN_W | Channel code, all ones disables |
| irq_en | input | 1 | Interrupt enable |
| dma_en | input | 1 | DMA request enable |
| ctl_wr | input | 1 | Control register write strobe |
| hw_trig | input | 1 | Hardware trigger pulse |
| result_rd | input | 1 | Result register read strobe |
| alt_tick | input | 1 | Alternate source tick |
| async_tick | input | 1 | Asynchronous source tick |
| accept | input | 1 | Downstream accepts the current result |
| active | output | 1 | Conversion in progress |
| done_flag | output | 1 | Conversion complete flag |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |
| result_stb | output | 1 | Last conversion cycle ends at this edge |

## Verification
The assertions rely on a few things about the inputs.
- `ctl_wr`, `hw_trig` and `result_rd` are single-cycle strobes that are aligned to the bus clock.
- `accept` is meaningful only in the cycle of `result_stb`.
- The configuration fields stay still while a conversion runs. Only the channel code and the trigger select are read at the start.

The stimulus follows these rules. It changes every input on the falling edge. It changes configuration only while the block is idle or at the moment of a control write. It raises no trigger in the same cycle as a control write.

// File: rtl/adc_seq_pkg.sv
// Package: shared widths and the phase-length arithmetic of the sequencer.
// Assumes at most 24 sample cycles and 22 conversion cycles, so 6 bits suffice.
package adc_seq_pkg;

    localparam int LEN_W = 6;

    // Sample-phase length in conversion-clock cycles.
    function automatic logic [LEN_W-1:0] sample_len(input logic long_en,
                                                    input logic [1:0] long_sel);
        logic [LEN_W-1:0] n;
        if (!long_en) begin
            n = LEN_W'(4);
        end else begin
            case (long_sel)
                2'b00:   n = LEN_W'(24);
                2'b01:   n = LEN_W'(16);
                2'b10:   n = LEN_W'(10);
                default: n = LEN_W'(6);
            endcase
        end
        return n;
    endfunction

    // Conversion-phase length: one cycle per bit, 4 overhead, 2 more in high speed.
    function automatic logic [LEN_W-1:0] convert_len(input logic [1:0] mode,
                                                     input logic hs);
        logic [LEN_W-1:0] bits;
        case (mode)
            2'b00:   bits = LEN_W'(8);
            2'b01:   bits = LEN_W'(12);
            2'b10:   bits = LEN_W'(10);
            default: bits = LEN_W'(16);
        endcase
        return bits + LEN_W'(4) + (hs ? LEN_W'(2) : LEN_W'(0));
    endfunction

endpackage

// File: rtl/adc_tick_gen.sv
// Tick generator: selects a source tick and divides it into the conversion clock.
// Assumes alt_tick and async_tick are already synchronous one-cycle enables.
// The prescaler restarts on every start so conversion timing is deterministic.
module adc_tick_gen #(
    parameter int DIVC_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       run,
    input  logic [1:0] src_sel,
    input  logic [1:0] div_sel,
    input  logic       alt_tick,
    input  logic       async_tick,
    output logic       adck_tick
);
    logic              half_q;
    logic              src_tick;
    logic [DIVC_W-1:0] div_cnt;
    logic [DIVC_W-1:0] ratio_m1;

    // Half-rate bus toggle, aligned to the start of a conversion.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) half_q <= 1'b0;
        else if (run)          half_q <= ~half_q;
    end

    // Source tick multiplexer, gated by the run state.
    always_comb begin
        case (src_sel)
            2'b00:   src_tick = run;
            2'b01:   src_tick = run & half_q;
            2'b10:   src_tick = run & alt_tick;
            default: src_tick = run & async_tick;
        endcase
    end

    // Terminal count of the divider for the chosen ratio.
    always_comb ratio_m1 = DIVC_W'((32'd1 << div_sel) - 32'd1);

    // Divider counter over source ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)       div_cnt <= '0;
        else if (src_tick)           div_cnt <= (div_cnt == ratio_m1) ? '0 : div_cnt + 1'b1;
    end

    // One conversion-clock tick per full divider period.
    assign adck_tick = src_tick && (div_cnt == ratio_m1);

endmodule

// File: rtl/adc_seq_core.sv
// Sequencer core: counts conversion-clock ticks across the sample and convert phases.
// Assumes len_total is at least 1 and is sampled only on start.
module adc_seq_core
    import adc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic             tick,
    input  logic             cont_en,
    input  logic [LEN_W-1:0] len_total,
    output logic             active,
    output logic             last
);
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] total_q;

    // Final tick of the conversion, suppressed by a concurrent abort.
    assign last = active && tick && (cnt_q == total_q - 1'b1) && !abort;

    // Run state and tick counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            cnt_q   <= '0;
            total_q <= '0;
        end else if (start) begin
            active  <= 1'b1;
            cnt_q   <= '0;
            total_q <= len_total;
        end else if (abort) begin
            active  <= 1'b0;
            cnt_q   <= '0;
        end else if (last) begin
            active  <= cont_en;
            cnt_q   <= '0;
        end else if (active && tick) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/adc_flag_ctl.sv
// Completion flag with its interrupt and DMA request outputs.
// Assumes clear and a set never matter together: a control write suppresses the strobe.
module adc_flag_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic set_stb,
    input  logic wr_clr,
    input  logic rd_clr,
    input  logic irq_en,
    input  logic dma_en,
    output logic done_flag,
    output logic irq,
    output logic dma_req
);
    // Flag update: a write clears, a set beats a read, a read clears.
    always_ff @(posedge clk) begin
        if (!rst_n)       done_flag <= 1'b0;
        else if (wr_clr)  done_flag <= 1'b0;
        else if (set_stb) done_flag <= 1'b1;
        else if (rd_clr)  done_flag <= 1'b0;
    end

    assign irq     = done_flag & irq_en;
    assign dma_req = done_flag & dma_en;

endmodule

// File: rtl/adc_conv_timer.sv
// Top: decodes triggers and the channel code, and ties the tick generator,
// sequencer core and flag logic together. Assumes strobes are one bus cycle wide.
module adc_conv_timer
    import adc_seq_pkg::*;
#(
    parameter int CHAN_W = 5,
    parameter int DIVC_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        src_sel,
    input  logic [1:0]        div_sel,
    input  logic              long_smp_en,
    input  logic [1:0]        long_smp_sel,
    input  logic              hs_en,
    input  logic              hw_trig_sel,
    input  logic              cont_en,
    input  logic [1:0]        res_mode,
    input  logic [CHAN_W-1:0] chan_sel,
    input  logic              irq_en,
    input  logic              dma_en,
    input  logic              ctl_wr,
    input  logic              hw_trig,
    input  logic              result_rd,
    input  logic              alt_tick,
    input  logic              async_tick,
    input  logic              accept,
    output logic              active,
    output logic              done_flag,
    output logic              irq,
    output logic              dma_req,
    output logic              result_stb
);
    localparam logic [CHAN_W-1:0] CHAN_OFF = {CHAN_W{1'b1}};

    logic             chan_off;
    logic             sw_start;
    logic             hw_start;
    logic             start;
    logic             adck_tick;
    logic [LEN_W-1:0] len_total;

    // Trigger decode: a write starts in software mode, a pulse starts in hardware mode.
    always_comb begin
        chan_off  = (chan_sel == CHAN_OFF);
        sw_start  = ctl_wr && !hw_trig_sel && !chan_off;
        hw_start  = hw_trig && hw_trig_sel && !chan_off && !active && !ctl_wr;
        start     = sw_start || hw_start;
        len_total = sample_len(long_smp_en, long_smp_sel) + convert_len(res_mode, hs_en);
    end

    adc_tick_gen #(.DIVC_W(DIVC_W)) u_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (start),
        .run        (active),
        .src_sel    (src_sel),
        .div_sel    (div_sel),
        .alt_tick   (alt_tick),
        .async_tick (async_tick),
        .adck_tick  (adck_tick)
    );

    adc_seq_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .abort     (ctl_wr),
        .tick      (adck_tick),
        .cont_en   (cont_en),
        .len_total (len_total),
        .active    (active),
        .last      (result_stb)
    );

    adc_flag_ctl u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_stb   (result_stb && accept),
        .wr_clr    (ctl_wr),
        .rd_clr    (result_rd),
        .irq_en    (irq_en),
        .dma_en    (dma_en),
        .done_flag (done_flag),
        .irq       (irq),
        .dma_req   (dma_req)
    );

endmodule

// File: rtl/adc_conv_timer_chk.sv
// Checker: temporal properties of the sequencer, observed at the top-level ports.
// Assumes the input conventions stated in the brief.
module adc_conv_timer_chk #(
    parameter int CHAN_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hw_trig_sel,
    input logic [CHAN_W-1:0] chan_sel,
    input logic              ctl_wr,
    input logic              result_rd,
    input logic              accept,
    input logic              active,
    input logic              done_flag,
    input logic              irq,
    input logic              dma_req,
    input logic              result_stb
);
    a_r9_no_start_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(chan_sel) != {CHAN_W{1'b1}});

    a_r5_idle_stays_idle_sw: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !ctl_wr && !hw_trig_sel) |=> !active);

    a_r10_flag_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> $past(result_stb && accept));

    a_r11_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> !done_flag);

    a_r11_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (result_rd && !result_stb) |=> !done_flag);

    a_r7_strobe_while_active: assert property (@(posedge clk) disable iff (!rst_n)
        result_stb |-> active);

    a_r12_requests_need_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (irq || dma_req) |-> done_flag);

endmodule

bind adc_conv_timer adc_conv_timer_chk #(.CHAN_W(CHAN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hw_trig_sel (hw_trig_sel),
    .chan_sel    (chan_sel),
    .ctl_wr      (ctl_wr),
    .result_rd   (result_rd),
    .accept      (accept),
    .active      (active),
    .done_flag   (done_flag),
    .irq         (irq),
    .dma_req     (dma_req),
    .result_stb  (result_stb)
);

// File: tb/adc_conv_timer_tb.sv
// Bench: a vector table of timing configurations, then directed tests.
module adc_conv_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] src_sel = 2'b00, div_sel = 2'b00, long_smp_sel = 2'b00, res_mode = 2'b00;
    logic       long_smp_en = 1'b0, hs_en = 1'b0, hw_trig_sel = 1'b0, cont_en = 1'b0;
    logic [4:0] chan_sel = 5'd3;
    logic       irq_en = 1'b0, dma_en = 1'b0, ctl_wr = 1'b0, hw_trig = 1'b0, result_rd = 1'b0;
    logic       alt_tick = 1'b1, async_tick = 1'b1, accept = 1'b1;
    logic       active, done_flag, irq, dma_req, result_stb;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    adc_conv_timer u_dut (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .div_sel(div_sel),
        .long_smp_en(long_smp_en), .long_smp_sel(long_smp_sel), .hs_en(hs_en),
        .hw_trig_sel(hw_trig_sel), .cont_en(cont_en), .res_mode(res_mode),
        .chan_sel(chan_sel), .irq_en(irq_en), .dma_en(dma_en), .ctl_wr(ctl_wr),
        .hw_trig(hw_trig), .result_rd(result_rd), .alt_tick(alt_tick),
        .async_tick(async_tick), .accept(accept), .active(active),
        .done_flag(done_flag), .irq(irq), .dma_req(dma_req), .result_stb(result_stb)
    );

    // Fields: src[21:20] div[19:18] long[17] lsel[16:15] hs[14] mode[13:12] cycles[11:0]
    localparam logic [21:0] VEC [0:8] = '{
        {2'b00, 2'b00, 1'b0, 2'b00, 1'b0, 2'b00, 12'd16},
        {2'b00, 2'b01, 1'b0, 2'b00, 1'b0, 2'b01, 12'd40},
        {2'b01, 2'b00, 1'b1, 2'b00, 1'b0, 2'b10, 12'd76},
        {2'b00, 2'b10, 1'b1, 2'b01, 1'b1, 2'b11, 12'd152},
        {2'b01, 2'b11, 1'b1, 2'b10, 1'b1, 2'b00, 12'd384},
        {2'b00, 2'b00, 1'b1, 2'b11, 1'b0, 2'b01, 12'd22},
        {2'b00, 2'b11, 1'b0, 2'b00, 1'b0, 2'b11, 12'd192},
        {2'b10, 2'b01, 1'b0, 2'b00, 1'b0, 2'b00, 12'd32},
        {2'b11, 2'b00, 1'b0, 2'b00, 1'b1, 2'b10, 12'd20}
    };

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_wr();
        @(negedge clk) ctl_wr = 1'b1;
        @(negedge clk) ctl_wr = 1'b0;
    endtask

    // Count negedges after the start edge until the complete flag is seen.
    task automatic wait_done(output int n);
        n = 0;
        while (!done_flag && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #400000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int n;
        int gap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7: reset state
        check(!active && !done_flag && !irq && !dma_req, "R7 reset", int'(active), 0);

        // R1 R2 R3 R4 R7: table of timing configurations
        for (int i = 0; i < 9; i++) begin
            {src_sel, div_sel, long_smp_en, long_smp_sel, hs_en, res_mode} = VEC[i][21:12];
            pulse_wr();
            wait_done(n);
            check(n == int'(VEC[i][11:0]), "R4 duration", n, int'(VEC[i][11:0]));
            check(!active, "R7 active ends", int'(active), 0);
        end
        {src_sel, div_sel, long_smp_en, long_smp_sel, hs_en, res_mode} = 10'd0;

        // R12: interrupt and DMA enables
        irq_en = 1'b1; dma_en = 1'b0;
        @(negedge clk);
        check(irq && !dma_req, "R12 irq only", int'({irq, dma_req}), 2);
        irq_en = 1'b0; dma_en = 1'b1;
        @(negedge clk);
        check(!irq && dma_req, "R12 dma only", int'({irq, dma_req}), 1);

        // R11: read clears the flag
        @(negedge clk) result_rd = 1'b1;
        @(negedge clk) result_rd = 1'b0;
        check(!done_flag && !dma_req, "R11 read clears", int'(done_flag), 0);

        // R11: a write clears, and a mid-run write restarts the full duration
        pulse_wr();
        wait_done(n);
        pulse_wr();
        check(!done_flag, "R11 write clears", int'(done_flag), 0);
        repeat (5) @(negedge clk);
        pulse_wr();
        wait_done(n);
        check(n == 16, "R11 abort restart", n, 16);

        // R9: disabled channel starts nothing
        chan_sel = 5'h1F;
        pulse_wr();
        repeat (20) @(negedge clk);
        check(!active && !done_flag, "R9 disabled no start", int'(active), 0);
        chan_sel = 5'd3;

        // R5: hardware pulse ignored in software mode
        @(negedge clk) hw_trig = 1'b1;
        @(negedge clk) hw_trig = 1'b0;
        repeat (3) @(negedge clk);
        check(!active, "R5 hw ignored", int'(active), 0);

        // R6: write does not start in hardware mode, pulse does
        hw_trig_sel = 1'b1;
        pulse_wr();
        repeat (5) @(negedge clk);
        check(!active, "R6 write no start", int'(active), 0);
        @(negedge clk) hw_trig = 1'b1;
        @(negedge clk) hw_trig = 1'b0;
        wait_done(n);
        check(n == 16, "R6 hw duration", n, 16);

        // R9: hardware pulse with disabled channel
        chan_sel = 5'h1F;
        @(negedge clk) hw_trig = 1'b1;
        @(negedge clk) hw_trig = 1'b0;
        repeat (3) @(negedge clk);
        check(!active, "R9 hw disabled", int'(active), 0);
        chan_sel = 5'd3;
        hw_trig_sel = 1'b0;

        // R8: continuous strobes spaced by one duration, stopped by a disabling write
        cont_en = 1'b1;
        pulse_wr();
        while (!result_stb) @(negedge clk);
        gap = 0;
        @(negedge clk);
        gap++;
        while (!result_stb && gap < 200) begin
            @(negedge clk);
            gap++;
        end
        check(gap == 16, "R8 spacing", gap, 16);
        check(active, "R8 still active", int'(active), 1);
        chan_sel = 5'h1F;
        pulse_wr();
        cont_en = 1'b0;
        repeat (3) @(negedge clk);
        check(!active, "R9 write stops", int'(active), 0);
        chan_sel = 5'd3;

        // R10: strobe without accept leaves the flag clear
        accept = 1'b0;
        pulse_wr();
        n = 0;
        while (active && n < 200) begin
            @(negedge clk);
            n++;
        end
        check(n == 16 && !done_flag, "R10 no accept", int'(done_flag), 0);
        accept = 1'b1;

        // R1: stalled alternate tick holds the conversion
        src_sel = 2'b10;
        alt_tick = 1'b0;
        pulse_wr();
        repeat (50) @(negedge clk);
        check(active && !done_flag, "R1 alt stall", int'(active), 1);
        alt_tick = 1'b1;
        wait_done(n);
        check(done_flag, "R1 alt resumes", int'(done_flag), 1);

        finish_run();
    end

endmodule